// File: doc/BRIEF.md
# Packed halfword signed multiply-accumulate datapath

This block is the arithmetic core of a packed-halfword multiply unit. It takes two data words split into signed halfword lanes, an accumulator given as a low word and a high word, and a seven-bit operation code. It forms one of three kinds of value. The first is a single halfword product, with each operand's halfword chosen on its own. The second is a halfword-by-word product cut down to its upper word. The third is the sum or difference of two lane products formed side by side. The block can then add that value into a one-word or a two-word accumulator.

The result is registered, so it is valid one clock after the operation is issued. A sticky overflow flag records any signed overflow that the flag-setting operations hit. The written result always wraps and is never clamped. The flag only clears when the clear input is asserted. Operand fetch, decode and hazard handling belong to the surrounding pipeline.

Top module: `hmac_dp`

## Requirements
- R1: Code bits [2:0] select the kind: 0 single multiply, 1 single multiply with word accumulate, 2 single multiply with doubleword accumulate, 3 halfword-by-word multiply, 4 halfword-by-word with word accumulate, 5 dual, 6 dual with word accumulate, 7 dual with doubleword accumulate. For kinds 0 to 2, bit 3 picks the top (1) or bottom (0) halfword of source A and bit 4 does the same for source B. The product is the 32-bit signed product of the two halfwords.
- R2: Kinds 3 and 4 multiply the whole of source A by the halfword of source B picked by bit 4, and take bits [47:16] of the 48-bit signed product.
- R3: Kinds 1, 4 and 6 add the value to the low accumulator word. The low result is the wrapped 32-bit sum. For every kind other than 2 and 7, the high result word is zero and the high accumulator word has no effect.
- R4: The flag is set when the exact value, after accumulation, lies outside the signed 32-bit range. This applies to kinds 1, 4 and 6, and to kind 5 with bit 6 clear.
- R5: Kind 2 adds the sign-extended product into the 64-bit accumulator {high, low}. The result wraps modulo 2^64 and never sets the flag. Kinds 0 and 3 never set the flag.
- R6: Dual kinds form lane 0 (bottom halves) and lane 1 (top halves) products. With bit 6 clear the value is lane 0 plus lane 1; with bit 6 set it is lane 0 minus lane 1.
- R7: In dual kinds, bit 5 swaps the two halfwords of source B before the lane products are formed.
- R8: Kind 7 adds the sign-extended dual value into the 64-bit accumulator with wrap. The flag is set only when bit 6 is set and the exact sum lies outside the signed 64-bit range.
- R9: The result and the valid output update on the clock edge that samples an issue, so they appear one cycle later. With no issue, valid is low, the result holds and the flag is not set.
- R10: The flag is sticky. A clear input empties it on the next edge, but a set from an operation issued in the same cycle wins over the clear.
- R11: After reset, valid, both result words and the flag are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_issue | input | 1 | Operation issued this cycle |
| i_opc | input | 7 | Operation code: {diff, exchange, B-top, A-top, kind[2:0]} |
| i_src_a | input | 32 | First source word |
| i_src_b | input | 32 | Second source word |
| i_acc_lo | input | 32 | Accumulator low word |
| i_acc_hi | input | 32 | Accumulator high word |
| i_q_clr | input | 1 | Clear the sticky overflow flag |
| o_valid | output | 1 | Result valid, one cycle after issue |
| o_res_lo | output | 32 | Result low word |
| o_res_hi | output | 32 | Result high word (zero for one-word kinds) |
| o_q | output | 1 | Sticky overflow flag |

## Verification
The bench builds the block with its default word width of 32. At this width, the extreme operand values can be written as plain literals: the most negative halfword squared, a 48-bit product whose discarded low half is negative, and accumulators sitting one step from the signed 32-bit and 64-bit limits. Every flag-setting and wrap-only path can therefore be pushed across its boundary directly. Each table row clears the flag while it issues, so the row shows only its own flag. Separate directed steps cover stickiness and the ignored-issue case.

// File: rtl/hmac_pkg.sv
package hmac_pkg;

  typedef enum logic [2:0] {
    K_MUL16  = 3'd0,
    K_MAC16  = 3'd1,
    K_MACL16 = 3'd2,
    K_MULW   = 3'd3,
    K_MACW   = 3'd4,
    K_DUAL   = 3'd5,
    K_DUALA  = 3'd6,
    K_DUALL  = 3'd7
  } kind_e;

  typedef struct packed {
    logic  diff;
    logic  xchg;
    logic  b_hi;
    logic  a_hi;
    kind_e kind;
  } opc_t;

  localparam int OPC_W = $bits(opc_t);

  function automatic logic is_dual(input kind_e k);
    return (k == K_DUAL) || (k == K_DUALA) || (k == K_DUALL);
  endfunction

  function automatic logic is_word(input kind_e k);
    return (k == K_MULW) || (k == K_MACW);
  endfunction

  function automatic logic adds_acc32(input kind_e k);
    return (k == K_MAC16) || (k == K_MACW) || (k == K_DUALA);
  endfunction

  function automatic logic is_wide(input kind_e k);
    return (k == K_MACL16) || (k == K_DUALL);
  endfunction

  function automatic logic flags32(input kind_e k, input logic diff);
    return adds_acc32(k) || ((k == K_DUAL) && !diff);
  endfunction

  function automatic logic flags64(input kind_e k, input logic diff);
    return (k == K_DUALL) && diff;
  endfunction

endpackage

// File: rtl/hmac_lanes.sv
module hmac_lanes
  import hmac_pkg::*;
#(
  parameter int DW = 32
) (
  input  kind_e                 kind,
  input  logic                  a_hi,
  input  logic                  b_hi,
  input  logic                  xchg,
  input  logic [DW-1:0]         src_a,
  input  logic [DW-1:0]         src_b,
  output logic [1:0][DW-1:0]    prod,
  output logic [DW-1:0]         wtop
);

  localparam int HW = DW / 2;
  localparam int NL = 2;
  localparam int FW = DW + HW;

  function automatic logic [DW-1:0] hprod(input logic [HW-1:0] x, input logic [HW-1:0] y);
    return $signed({{HW{x[HW-1]}}, x}) * $signed({{HW{y[HW-1]}}, y});
  endfunction

  logic          dual;
  logic          swap;
  logic [HW-1:0] a_h  [NL];
  logic [HW-1:0] b_h  [NL];
  logic [HW-1:0] bx_h [NL];

  assign dual = is_dual(kind);
  assign swap = dual && xchg;

  for (genvar k = 0; k < NL; k++) begin : g_split
    assign a_h[k]  = src_a[k*HW +: HW];
    assign b_h[k]  = src_b[k*HW +: HW];
    assign bx_h[k] = swap ? src_b[(NL-1-k)*HW +: HW] : src_b[k*HW +: HW];
  end

  for (genvar k = 0; k < NL; k++) begin : g_lane
    logic [HW-1:0] x;
    logic [HW-1:0] y;
    if (k == 0) begin : g_sel
      always_comb begin
        if (dual) begin
          x = a_h[0];
          y = bx_h[0];
        end else begin
          x = a_h[a_hi];
          y = b_h[b_hi];
        end
      end
    end else begin : g_fix
      assign x = a_h[k];
      assign y = bx_h[k];
    end
    assign prod[k] = hprod(x, y);
  end

  // halfword-by-word product, upper word of the full product
  logic [HW-1:0]        wh;
  logic signed [FW-1:0] wfull;

  assign wh    = b_h[b_hi];
  assign wfull = $signed({{HW{src_a[DW-1]}}, src_a}) * $signed({{DW{wh[HW-1]}}, wh});
  assign wtop  = DW'(wfull >>> HW);

endmodule

// File: rtl/hmac_combine.sv
module hmac_combine
  import hmac_pkg::*;
#(
  parameter int DW = 32
) (
  input  kind_e              kind,
  input  logic               diff,
  input  logic [1:0][DW-1:0] prod,
  input  logic [DW-1:0]      wtop,
  output logic [DW:0]        term
);

  function automatic logic [DW:0] sx1(input logic [DW-1:0] v);
    return {v[DW-1], v};
  endfunction

  logic [DW:0] dual_val;

  assign dual_val = diff ? (sx1(prod[0]) - sx1(prod[1]))
                         : (sx1(prod[0]) + sx1(prod[1]));

  always_comb begin
    if (is_dual(kind))      term = dual_val;
    else if (is_word(kind)) term = sx1(wtop);
    else                    term = sx1(prod[0]);
  end

endmodule

// File: rtl/hmac_accum.sv
module hmac_accum
  import hmac_pkg::*;
#(
  parameter int DW = 32
) (
  input  kind_e         kind,
  input  logic          diff,
  input  logic [DW:0]   term,
  input  logic [DW-1:0] acc_lo,
  input  logic [DW-1:0] acc_hi,
  output logic [DW-1:0] res_lo,
  output logic [DW-1:0] res_hi,
  output logic          ovf_evt
);

  localparam int NW = DW + 2;
  localparam int LW = 2 * DW + 1;
  localparam int TW = NW - DW + 1;

  logic [NW-1:0] sum32;
  logic [LW-1:0] sum64;
  logic [TW-1:0] top32;
  logic          fits32;
  logic          fits64;

  assign sum32 = {term[DW], term}
               + (adds_acc32(kind) ? {{2{acc_lo[DW-1]}}, acc_lo} : {NW{1'b0}});
  assign sum64 = {{(LW-DW-1){term[DW]}}, term} + {acc_hi[DW-1], acc_hi, acc_lo};

  assign top32  = sum32[NW-1:DW-1];
  assign fits32 = (&top32) || !(|top32);
  assign fits64 = (sum64[LW-1] == sum64[LW-2]);

  always_comb begin
    if (is_wide(kind)) begin
      res_lo = sum64[DW-1:0];
      res_hi = sum64[2*DW-1:DW];
    end else begin
      res_lo = sum32[DW-1:0];
      res_hi = '0;
    end
  end

  assign ovf_evt = (flags32(kind, diff) && !fits32) || (flags64(kind, diff) && !fits64);

endmodule

// File: rtl/hmac_dp.sv
module hmac_dp
  import hmac_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             i_issue,
  input  logic [OPC_W-1:0] i_opc,
  input  logic [DW-1:0]    i_src_a,
  input  logic [DW-1:0]    i_src_b,
  input  logic [DW-1:0]    i_acc_lo,
  input  logic [DW-1:0]    i_acc_hi,
  input  logic             i_q_clr,
  output logic             o_valid,
  output logic [DW-1:0]    o_res_lo,
  output logic [DW-1:0]    o_res_hi,
  output logic             o_q
);

  opc_t               opc;
  logic [1:0][DW-1:0] prod;
  logic [DW-1:0]      wtop;
  logic [DW:0]        term;
  logic [DW-1:0]      nxt_lo;
  logic [DW-1:0]      nxt_hi;
  logic               ovf_evt;
  logic               q_set;

  assign opc = opc_t'(i_opc);

  hmac_lanes #(.DW(DW)) u_lanes (
    .kind  (opc.kind),
    .a_hi  (opc.a_hi),
    .b_hi  (opc.b_hi),
    .xchg  (opc.xchg),
    .src_a (i_src_a),
    .src_b (i_src_b),
    .prod  (prod),
    .wtop  (wtop)
  );

  hmac_combine #(.DW(DW)) u_comb (
    .kind (opc.kind),
    .diff (opc.diff),
    .prod (prod),
    .wtop (wtop),
    .term (term)
  );

  hmac_accum #(.DW(DW)) u_acc (
    .kind    (opc.kind),
    .diff    (opc.diff),
    .term    (term),
    .acc_lo  (i_acc_lo),
    .acc_hi  (i_acc_hi),
    .res_lo  (nxt_lo),
    .res_hi  (nxt_hi),
    .ovf_evt (ovf_evt)
  );

  assign q_set = i_issue && ovf_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_valid  <= 1'b0;
      o_res_lo <= '0;
      o_res_hi <= '0;
      o_q      <= 1'b0;
    end else begin
      o_valid <= i_issue;
      if (i_issue) begin
        o_res_lo <= nxt_lo;
        o_res_hi <= nxt_hi;
      end
      o_q <= (o_q && !i_q_clr) || q_set;
    end
  end

endmodule

// File: rtl/hmac_dp_chk.sv
module hmac_dp_chk
  import hmac_pkg::*;
#(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          i_issue,
  input kind_e         ck_kind,
  input logic          ck_diff,
  input logic          i_q_clr,
  input logic          o_valid,
  input logic [DW-1:0] o_res_lo,
  input logic [DW-1:0] o_res_hi,
  input logic          o_q,
  input logic          ovf_evt
);

  a_r9_valid_follows_issue: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid == $past(i_issue));

  a_r9_hold_without_issue: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(i_issue) |-> ($stable(o_res_lo) && $stable(o_res_hi)));

  a_r10_q_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(o_q) && !$past(i_q_clr)) |-> o_q);

  a_r10_q_rise_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(o_q) |-> $past(i_issue && ovf_evt));

  a_r3_narrow_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !$past(is_wide(ck_kind))) |-> (o_res_hi == '0));

  a_r5_flagless_kinds: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |-> (flags32(ck_kind, ck_diff) || flags64(ck_kind, ck_diff)));

endmodule

bind hmac_dp hmac_dp_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .i_issue  (i_issue),
  .ck_kind  (opc.kind),
  .ck_diff  (opc.diff),
  .i_q_clr  (i_q_clr),
  .o_valid  (o_valid),
  .o_res_lo (o_res_lo),
  .o_res_hi (o_res_hi),
  .o_q      (o_q),
  .ovf_evt  (ovf_evt)
);

// File: tb/sim_hmac_dp.sv
module sim_hmac_dp;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        i_issue = 1'b0;
  logic [6:0]  i_opc = '0;
  logic [31:0] i_src_a = '0;
  logic [31:0] i_src_b = '0;
  logic [31:0] i_acc_lo = '0;
  logic [31:0] i_acc_hi = '0;
  logic        i_q_clr = 1'b0;
  logic        o_valid;
  logic [31:0] o_res_lo;
  logic [31:0] o_res_hi;
  logic        o_q;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hmac_dp u0 (
    .clk(clk), .rst_n(rst_n), .i_issue(i_issue), .i_opc(i_opc),
    .i_src_a(i_src_a), .i_src_b(i_src_b), .i_acc_lo(i_acc_lo), .i_acc_hi(i_acc_hi),
    .i_q_clr(i_q_clr), .o_valid(o_valid), .o_res_lo(o_res_lo), .o_res_hi(o_res_hi),
    .o_q(o_q)
  );

  typedef struct packed {
    logic [6:0]  opc;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] alo;
    logic [31:0] ahi;
    logic [31:0] elo;
    logic [31:0] ehi;
    logic        eq;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t TBL [NV] = '{
    '{7'h00, 32'h0005_0003, 32'h0007_FFFE, 32'h0, 32'h0,        32'hFFFF_FFFA, 32'h0, 1'b0}, // R1 bot*bot
    '{7'h08, 32'h0005_0003, 32'h0007_FFFE, 32'h0, 32'h0,        32'hFFFF_FFF6, 32'h0, 1'b0}, // R1 top*bot
    '{7'h10, 32'h0005_0003, 32'h0007_FFFE, 32'h0, 32'h0,        32'h0000_0015, 32'h0, 1'b0}, // R1 bot*top
    '{7'h18, 32'h0005_0003, 32'h0007_FFFE, 32'h0, 32'h0,        32'h0000_0023, 32'h0, 1'b0}, // R1 top*top
    '{7'h00, 32'h0000_8000, 32'h0000_8000, 32'h0, 32'h0,        32'h4000_0000, 32'h0, 1'b0}, // R1 R5 min squared
    '{7'h01, 32'h0000_0004, 32'h0000_0005, 32'd100, 32'hDEAD_BEEF, 32'h0000_0078, 32'h0, 1'b0}, // R3
    '{7'h01, 32'h0000_8000, 32'h0000_8000, 32'h4000_0000, 32'h0, 32'h8000_0000, 32'h0, 1'b1}, // R4
    '{7'h02, 32'h0000_FFFF, 32'h0000_0002, 32'h0, 32'h1,        32'hFFFF_FFFE, 32'h0, 1'b0}, // R5
    '{7'h02, 32'h0000_0001, 32'h0000_0001, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h0, 32'h8000_0000, 1'b0}, // R5 wrap
    '{7'h03, 32'hFFFF_0000, 32'h0000_0003, 32'h0, 32'h0,        32'hFFFF_FFFD, 32'h0, 1'b0}, // R2 bottom
    '{7'h13, 32'h0002_0000, 32'h0005_0000, 32'h0, 32'h0,        32'h0000_000A, 32'h0, 1'b0}, // R2 top
    '{7'h04, 32'h7FFF_FFFF, 32'h0000_7FFF, 32'h4000_8001, 32'h0, 32'h8000_0000, 32'h0, 1'b1}, // R2 R4
    '{7'h05, 32'h0002_0003, 32'h0004_0005, 32'h0, 32'h0,        32'h0000_0017, 32'h0, 1'b0}, // R6 sum
    '{7'h45, 32'h0002_0003, 32'h0004_0005, 32'h0, 32'h0,        32'h0000_0007, 32'h0, 1'b0}, // R6 diff
    '{7'h65, 32'h0002_0003, 32'h0004_0005, 32'h0, 32'h0,        32'h0000_0002, 32'h0, 1'b0}, // R7 diff exch
    '{7'h05, 32'h8000_8000, 32'h8000_8000, 32'h0, 32'h0,        32'h8000_0000, 32'h0, 1'b1}, // R4 R6 sum ovf
    '{7'h26, 32'h0002_0003, 32'h0004_0005, 32'd100, 32'h0,      32'h0000_007A, 32'h0, 1'b0}, // R7 R3
    '{7'h46, 32'h0002_0001, 32'h0001_0001, 32'h8000_0000, 32'h0, 32'h7FFF_FFFF, 32'h0, 1'b1}, // R4 underflow
    '{7'h07, 32'h0002_0003, 32'h0004_0005, 32'hFFFF_FFF0, 32'hFFFF_FFFF, 32'h0000_0007, 32'h0, 1'b0}, // R8
    '{7'h47, 32'h0001_0002, 32'h0001_0001, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h0, 32'h8000_0000, 1'b1}, // R8 diff ovf
    '{7'h07, 32'h0000_0001, 32'h0000_0001, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h0, 32'h8000_0000, 1'b0}  // R8 sum wrap
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [6:0] opc, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] alo, input logic [31:0] ahi,
                       input logic issue, input logic clr);
    @(negedge clk);
    i_opc = opc; i_src_a = a; i_src_b = b; i_acc_lo = alo; i_acc_hi = ahi;
    i_issue = issue; i_q_clr = clr;
    @(negedge clk);
    i_issue = 1'b0; i_q_clr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 valid", 64'(o_valid), 64'h0);
    check("R11 result", {o_res_hi, o_res_lo}, 64'h0);
    check("R11 flag", 64'(o_q), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].opc, TBL[i].a, TBL[i].b, TBL[i].alo, TBL[i].ahi, 1'b1, 1'b1);
      check($sformatf("R9 row %0d valid", i), 64'(o_valid), 64'h1);
      check($sformatf("row %0d low word", i), 64'(o_res_lo), 64'(TBL[i].elo));
      check($sformatf("R3 row %0d high word", i), 64'(o_res_hi), 64'(TBL[i].ehi));
      check($sformatf("R10 row %0d flag with clear", i), 64'(o_q), 64'(TBL[i].eq));
    end

    // R10 stickiness: set without clear, then an ordinary op keeps it
    drive(7'h01, 32'h0000_8000, 32'h0000_8000, 32'h4000_0000, 32'h0, 1'b1, 1'b0);
    check("R10 set", 64'(o_q), 64'h1);
    drive(7'h00, 32'h0005_0003, 32'h0007_FFFE, 32'h0, 32'h0, 1'b1, 1'b0);
    check("R10 stays set", 64'(o_q), 64'h1);
    check("R1 after sticky", 64'(o_res_lo), 64'hFFFF_FFFA);
    // R10 clear alone
    drive(7'h00, 32'h0, 32'h0, 32'h0, 32'h0, 1'b0, 1'b1);
    check("R10 cleared", 64'(o_q), 64'h0);
    check("R9 valid low without issue", 64'(o_valid), 64'h0);
    check("R9 result held", {o_res_hi, o_res_lo}, {32'h0, 32'hFFFF_FFFA});

    // R9 overflowing stimulus with no issue changes nothing
    drive(7'h04, 32'h7FFF_FFFF, 32'h0000_7FFF, 32'h4000_8001, 32'h0, 1'b0, 1'b0);
    check("R9 no flag without issue", 64'(o_q), 64'h0);
    check("R9 result held idle", {o_res_hi, o_res_lo}, {32'h0, 32'hFFFF_FFFA});
    @(negedge clk);
    check("R9 valid stays low", 64'(o_valid), 64'h0);

    // R9 valid is a single pulse
    drive(7'h05, 32'h0002_0003, 32'h0004_0005, 32'h0, 32'h0, 1'b1, 1'b0);
    check("R6 issue result", 64'(o_res_lo), 64'h17);
    @(negedge clk);
    check("R9 valid one cycle", 64'(o_valid), 64'h0);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule